// File: doc/BRIEF.md
# Carry-Skip Block Adder

This block adds two 16-bit operands and a carry input in pure combinational logic. The width is split into four groups of four bits. Each group ripples its carry bit by bit from per-bit generate and propagate terms. Alongside that chain, each group forms a bypass condition: every one of its bits propagates. When the bypass condition holds, a multiplexer hands the carry that entered the group straight to the next group, so the signal does not travel the group's internal chain. When it does not hold, the group itself either kills or creates the carry, so the carry that leaves it does not depend on the carry that entered.

The per-group bypass conditions are exported as a flag vector. A datapath around the adder, or a bench, can use them to count how often a carry skips a group. The block has no clock and no state. Outputs follow the inputs after the logic settles.

Top module: `csk_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `a_in + b_in + c_in`, taken as unsigned integers.
- R2: `c_out` equals bit 16 of the 17-bit unsigned sum `a_in + b_in + c_in`.
- R3: `skip_out[k]` is 1 exactly when `a_in[i] != b_in[i]` for every bit i of group k. Group k covers bits 4k to 4k+3, with group 0 holding the least significant bits.
- R4: When `skip_out[k]` is 1, the carry leaving group k equals the carry entering it. The carry entering group 0 is `c_in`. The carry entering group k>0 can be seen at the ports as `sum_out[4k] ^ a_in[4k] ^ b_in[4k]`. The carry leaving group 3 is `c_out`.
- R5: When `skip_out[k]` is 0, the carry leaving group k equals bit 4 of the 5-bit sum of the group's two operand nibbles, added with no carry in. It therefore does not depend on the carry entering the group.
- R6: With `a_in ^ b_in` all ones, all four skip flags are 1 and `c_out` equals `c_in`. In that case `sum_out` is 16'hFFFF when `c_in` is 0 and 16'h0000 when `c_in` is 1.
- R7: With both operands and `c_in` all zero, `sum_out`, `c_out` and `skip_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |
| skip_out | output | 4 | Per-group bypass flags, bit k for group k |

## Verification
Two things can happen in the same evaluation: a carry is created inside group k-1, and group k bypasses it onward, so the mux path carries a generated value rather than `c_in`. The bench provokes this by sweeping every operand nibble pair and both carry-in values in one group, while the neighbouring groups carry an all-propagate background on half of the vectors. The carry that enters and leaves each group is rebuilt from the sum and operand bits at the ports. The bench then judges that carry against the arithmetic sum and against the nibble-local carry, depending on the exported skip flag.

// File: rtl/csk_pkg.sv
package csk_pkg;

    localparam int unsigned CSK_WIDTH = 16;
    localparam int unsigned CSK_GRP   = 4;

    typedef struct packed {
        logic prop;
        logic gen;
    } pg_bit_t;

endpackage

// File: rtl/csk_pg_cell.sv
module csk_pg_cell
    import csk_pkg::*;
(
    input  logic    a_i,
    input  logic    b_i,
    output pg_bit_t pg_o
);

    pg_bit_t pg_d;

    always_comb begin
        pg_d.prop = a_i ^ b_i;
        pg_d.gen  = a_i & b_i;
    end

    assign pg_o = pg_d;

endmodule

// File: rtl/csk_group.sv
module csk_group
    import csk_pkg::*;
#(
    parameter int unsigned GRP = CSK_GRP
) (
    input  logic [GRP-1:0] a_i,
    input  logic [GRP-1:0] b_i,
    input  logic           ci_i,
    output logic [GRP-1:0] s_o,
    output logic           co_o,
    output logic           skip_o
);

    typedef struct packed {
        logic [GRP:0]   chain;
        logic [GRP-1:0] sum;
        logic           skip;
        logic           co;
    } grp_state_t;

    pg_bit_t [GRP-1:0] pg_w;
    grp_state_t        grp_d;

    for (genvar i = 0; i < GRP; i++) begin : g_bit
        csk_pg_cell u_pg (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .pg_o(pg_w[i])
        );
    end

    always_comb begin
        grp_d          = '0;
        grp_d.chain[0] = ci_i;
        grp_d.skip     = 1'b1;
        for (int i = 0; i < GRP; i++) begin
            grp_d.chain[i+1] = pg_w[i].gen | (pg_w[i].prop & grp_d.chain[i]);
            grp_d.sum[i]     = pg_w[i].prop ^ grp_d.chain[i];
            grp_d.skip       = grp_d.skip & pg_w[i].prop;
        end
        grp_d.co = grp_d.skip ? ci_i : grp_d.chain[GRP];
    end

    assign s_o    = grp_d.sum;
    assign co_o   = grp_d.co;
    assign skip_o = grp_d.skip;

endmodule

// File: rtl/csk_adder.sv
module csk_adder
    import csk_pkg::*;
#(
    parameter int unsigned WIDTH = CSK_WIDTH,
    parameter int unsigned GRP   = CSK_GRP
) (
    input  logic [WIDTH-1:0]     a_in,
    input  logic [WIDTH-1:0]     b_in,
    input  logic                 c_in,
    output logic [WIDTH-1:0]     sum_out,
    output logic                 c_out,
    output logic [WIDTH/GRP-1:0] skip_out
);

    localparam int unsigned NGRP = WIDTH / GRP;

    logic [NGRP:0] grp_chain;

    for (genvar k = 0; k < NGRP; k++) begin : g_grp
        logic ci_w;
        logic co_w;

        if (k == 0) begin : g_first
            assign ci_w = c_in;
        end else begin : g_next
            assign ci_w = g_grp[k-1].co_w;
        end

        csk_group #(.GRP(GRP)) u_grp (
            .a_i   (a_in[k*GRP +: GRP]),
            .b_i   (b_in[k*GRP +: GRP]),
            .ci_i  (ci_w),
            .s_o   (sum_out[k*GRP +: GRP]),
            .co_o  (co_w),
            .skip_o(skip_out[k])
        );

        assign grp_chain[k] = ci_w;
    end

    assign grp_chain[NGRP] = g_grp[NGRP-1].co_w;
    assign c_out           = grp_chain[NGRP];

endmodule

// File: rtl/csk_adder_chk.sv
module csk_adder_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GRP   = 4
) (
    input logic [WIDTH-1:0]     a_in,
    input logic [WIDTH-1:0]     b_in,
    input logic                 c_in,
    input logic [WIDTH-1:0]     sum_out,
    input logic                 c_out,
    input logic [WIDTH/GRP-1:0] skip_out,
    input logic [WIDTH/GRP:0]   chain
);

    localparam int unsigned NGRP = WIDTH / GRP;

    logic [WIDTH:0] total_w;
    assign total_w = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};

    always_comb begin
        // R1
        sum_total_chk: assert ({c_out, sum_out} == total_w);
        // R2
        cout_chain_chk: assert (c_out == chain[NGRP]);
        // R4
        entry_cin_chk: assert (chain[0] == c_in);
    end

    for (genvar k = 0; k < NGRP; k++) begin : g_chk
        logic [GRP-1:0] pa_w;
        logic [GRP:0]   nib_w;
        assign pa_w  = a_in[k*GRP +: GRP] ^ b_in[k*GRP +: GRP];
        assign nib_w = {1'b0, a_in[k*GRP +: GRP]} + {1'b0, b_in[k*GRP +: GRP]};

        always_comb begin
            // R4
            skip_pass_chk: assert (!skip_out[k] || (chain[k+1] == chain[k]));
            // R3
            skip_sum_chk: assert (!skip_out[k] || (sum_out[k*GRP +: GRP] == {GRP{~chain[k]}}));
            // R3
            skip_need_chk: assert (skip_out[k] || ($countones(pa_w) < GRP));
            // R5
            local_carry_chk: assert (skip_out[k] || (chain[k+1] == nib_w[GRP]));
        end
    end

endmodule

bind csk_adder csk_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) chk_i (
    .a_in    (a_in),
    .b_in    (b_in),
    .c_in    (c_in),
    .sum_out (sum_out),
    .c_out   (c_out),
    .skip_out(skip_out),
    .chain   (grp_chain)
);

// File: tb/csk_adder_tb_top.sv
module csk_adder_tb_top;

    localparam int W = 16;
    localparam int G = 4;
    localparam int N = W / G;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, s;
    logic         ci, co;
    logic [N-1:0] sk;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    csk_adder dut_i (
        .a_in(a), .b_in(b), .c_in(ci),
        .sum_out(s), .c_out(co), .skip_out(sk)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s a=%h b=%h ci=%0d act=%h exp=%h", req, a, b, ci, act, exp);
        end
    endtask

    function automatic logic grp_cin(input int k);
        if (k == 0) return ci;
        return s[k*G] ^ a[k*G] ^ b[k*G];
    endfunction

    function automatic logic grp_cout(input int k);
        if (k == N-1) return co;
        return grp_cin(k+1);
    endfunction

    task automatic run(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
        logic [W:0]   tot;
        logic [G:0]   nib;
        logic [N-1:0] exp_sk;
        @(posedge clk);
        a = av; b = bv; ci = cv;
        @(negedge clk);
        tot = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
        for (int k = 0; k < N; k++) exp_sk[k] = &(av[k*G +: G] ^ bv[k*G +: G]);
        chk(s == tot[W-1:0], "R1", {16'h0, s}, {16'h0, tot[W-1:0]});
        chk(co == tot[W], "R2", {31'h0, co}, {31'h0, tot[W]});
        chk(sk == exp_sk, "R3", {28'h0, sk}, {28'h0, exp_sk});
        for (int k = 0; k < N; k++) begin
            if (sk[k]) begin
                chk(grp_cout(k) == grp_cin(k), "R4", {31'h0, grp_cout(k)}, {31'h0, grp_cin(k)});
            end else begin
                nib = {1'b0, av[k*G +: G]} + {1'b0, bv[k*G +: G]};
                chk(grp_cout(k) == nib[G], "R5", {31'h0, grp_cout(k)}, {31'h0, nib[G]});
            end
        end
    endtask

    initial begin
        a = '0; b = '0; ci = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: all-zero inputs
        chk(s == '0, "R7", {16'h0, s}, 32'h0);
        chk(co == 1'b0, "R7", {31'h0, co}, 32'h0);
        chk(sk == '0, "R7", {28'h0, sk}, 32'h0);

        // R6: all-propagate, carry passes every group
        for (int c = 0; c < 2; c++) begin
            run(16'hA5C3, 16'h5A3C, c[0]);
            chk(sk == 4'hF, "R6", {28'h0, sk}, 32'hF);
            chk(co == c[0], "R6", {31'h0, co}, {31'h0, c[0]});
            chk(s == (c[0] ? 16'h0000 : 16'hFFFF), "R6", {16'h0, s}, c[0] ? 32'h0 : 32'hFFFF);
        end

        // Exhaustive nibble sweep in each group, background varied
        for (int g = 0; g < N; g++) begin
            for (int v = 0; v < 512; v++) begin
                logic [W-1:0] abg, bbg, av, bv;
                abg = W'($urandom);
                bbg = v[2] ? ~abg : W'($urandom);
                av = abg; bv = bbg;
                av[g*G +: G] = v[3:0];
                bv[g*G +: G] = v[7:4];
                run(av, bv, v[8]);
            end
        end

        // Directed: generate in a low group, bypass through all above
        run(16'hF0F8, 16'h0F08, 1'b0);
        run(16'h0FFF, 16'hF001, 1'b0);
        run(16'hFFFF, 16'h0001, 1'b0);
        run(16'hFFFF, 16'hFFFF, 1'b1);

        for (int i = 0; i < 1000; i++) run(W'($urandom), W'($urandom), 1'($urandom));

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule